// File: doc/BRIEF.md
# Synchronizing SCL Clock Generator

This block times the SCL clock of a bus master on an open-drain, wired-AND clock line. It counts a programmed number of system clocks with the line pulled low, then lets go of the line. It counts the high time only once the shared line has actually risen. Because it samples the real line level, it adapts to other devices. A competing master that pulls the line low during this block's high phase cuts that phase short and starts a fresh low phase here. A slave that keeps the line low holds this block in a waiting state. The low time seen on the line follows the slowest device and the high time follows the fastest one.

A bit engine uses the two one-cycle strobes to place data changes and samples. The line level input must already be synchronized to the system clock and filtered. The counts are plain control inputs and are read each time a phase begins. There is no streaming data path, so there is no valid/ready handshake.

Top module: `scl_sync_gen`

## Requirements
- R1: While reset is asserted, and on every cycle the block is disabled, `scl_pull`, `scl_wait`, `rise_stb` and `fall_stb` are all 0.
- R2: When `en` is sampled high while idle, `scl_pull` is 1 from the next cycle on. This starts a low phase.
- R3: A low phase keeps `scl_pull` at 1 for exactly max(`low_cnt`, 2) cycles. A value of 0 or 1 counts as 2.
- R4: After its low phase the block sets `scl_pull` to 0 and waits. `scl_wait` is 1 exactly on the cycles where the block is waiting and `scl_line` reads 0. A line held low by another device extends the wait for as long as it is held.
- R5: The high phase starts on the cycle after the waiting block samples `scl_line` = 1. Without interference it lasts max(`high_cnt`, 2) cycles (0 or 1 counts as 2), and then a new low phase begins. An undisturbed period is therefore low + 1 + high cycles.
- R6: If `scl_line` reads 0 during the high phase, the next cycle starts a low phase with `scl_pull` = 1. That low phase runs the full reloaded count of R3.
- R7: `rise_stb` is a one-cycle pulse on the first cycle of each high phase. `fall_stb` is a one-cycle pulse on the first cycle of each low phase entered from a high phase, whether that high phase ran out or was cut short. A low phase that starts from idle gives no `fall_stb`.
- R8: If `en` is sampled low in any phase, the next cycle has `scl_pull` = 0 and no strobes, and the block stays idle until `en` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run the clock generator |
| low_cnt | input | CW | Low phase length in system clocks (min 2) |
| high_cnt | input | CW | High phase length in system clocks (min 2) |
| scl_line | input | 1 | Synchronized level of the shared SCL line |
| scl_pull | output | 1 | 1 = drive the SCL line low |
| scl_wait | output | 1 | Released but line still held low by another device |
| rise_stb | output | 1 | First cycle of a high phase |
| fall_stb | output | 1 | First cycle of a low phase following a high phase |

## Verification
The bench builds the block with the default 8-bit count width. It programs counts from 0 to 14, so the clamp of 0 and 1 to 2 and short phases with frequent transitions are all reached in a few hundred cycles. The bench models the wired-AND line with two extra pull-down sources: a slave that stretches the low phase by a random number of cycles, and a competing master that pulls the line low in the middle of a high phase. This covers the wait path, the aborted high phase and the full reload of the low count.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;

  localparam int unsigned MIN_PHASE = 2;

endpackage

// File: rtl/scl_period_timer.sv
module scl_period_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic          last
);
  import scl_gen_pkg::*;

  localparam logic [CW-1:0] FLOOR = CW'(MIN_PHASE);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] start_val;

  // counts below the floor are raised to it
  assign start_val = (load_val < FLOOR) ? FLOOR : load_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= start_val;
    end else if (tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q <= CW'(1));

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     line_hi,
  input  logic                     tmr_last,
  output scl_gen_pkg::scl_phase_e  phase,
  output logic                     load_low,
  output logic                     load_high,
  output logic                     tick,
  output logic                     rise_q,
  output logic                     fall_q
);
  import scl_gen_pkg::*;

  scl_phase_e ph_q, ph_d;
  logic       rise_d, fall_d;

  always_comb begin
    ph_d      = ph_q;
    load_low  = 1'b0;
    load_high = 1'b0;
    tick      = 1'b0;
    rise_d    = 1'b0;
    fall_d    = 1'b0;
    if (!en) begin
      ph_d = PH_IDLE;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          ph_d     = PH_LOW;
          load_low = 1'b1;
        end
        PH_LOW: begin
          if (tmr_last) ph_d = PH_WAIT;
          else          tick = 1'b1;
        end
        PH_WAIT: begin
          if (line_hi) begin
            ph_d      = PH_HIGH;
            load_high = 1'b1;
            rise_d    = 1'b1;
          end
        end
        PH_HIGH: begin
          // another device pulling low, or our own high time used up
          if (!line_hi || tmr_last) begin
            ph_d     = PH_LOW;
            load_low = 1'b1;
            fall_d   = 1'b1;
          end else begin
            tick = 1'b1;
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign phase = ph_q;

endmodule

// File: rtl/scl_sync_gen.sv
module scl_sync_gen #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] low_cnt,
  input  logic [CW-1:0] high_cnt,
  input  logic          scl_line,
  output logic          scl_pull,
  output logic          scl_wait,
  output logic          rise_stb,
  output logic          fall_stb
);
  import scl_gen_pkg::*;

  scl_phase_e    phase;
  logic          load_low, load_high, tick, tmr_last;
  logic [CW-1:0] load_val;

  assign load_val = load_high ? high_cnt : low_cnt;

  scl_period_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_low | load_high),
    .load_val (load_val),
    .tick     (tick),
    .last     (tmr_last)
  );

  scl_phase_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .line_hi   (scl_line),
    .tmr_last  (tmr_last),
    .phase     (phase),
    .load_low  (load_low),
    .load_high (load_high),
    .tick      (tick),
    .rise_q    (rise_stb),
    .fall_q    (fall_stb)
  );

  assign scl_pull = (phase == PH_LOW);
  assign scl_wait = (phase == PH_WAIT) && !scl_line;

endmodule

// File: rtl/scl_sync_gen_chk.sv
module scl_sync_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic scl_line,
  input logic scl_pull,
  input logic scl_wait,
  input logic rise_stb,
  input logic fall_stb
);

  // R4
  wait_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_wait |-> (!scl_pull && !scl_line));

  // R3
  low_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl_pull) && en) |=> scl_pull);

  // R5
  rise_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> ($past(scl_line) && !scl_pull));

  // R7
  fall_with_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> scl_pull);

  // R7
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |=> !fall_stb);

  // R8
  disable_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_pull && !rise_stb && !fall_stb));

endmodule

bind scl_sync_gen scl_sync_gen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .scl_line (scl_line),
  .scl_pull (scl_pull),
  .scl_wait (scl_wait),
  .rise_stb (rise_stb),
  .fall_stb (fall_stb)
);

// File: tb/scl_sync_gen_tb.sv
module scl_sync_gen_tb;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [CW-1:0] low_cnt = '0;
  logic [CW-1:0] high_cnt = '0;
  logic          other_low = 1'b0;
  logic          slave_low = 1'b0;
  logic          scl_line;
  logic          scl_pull, scl_wait, rise_stb, fall_stb;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  assign scl_line = !(scl_pull | other_low | slave_low);

  scl_sync_gen #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .low_cnt(low_cnt), .high_cnt(high_cnt),
    .scl_line(scl_line), .scl_pull(scl_pull), .scl_wait(scl_wait),
    .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  function automatic int exp_len(int v);
    return (v < 2) ? 2 : v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_run(input int lo, input int hi);
    en = 1'b0;
    repeat (2) @(negedge clk);
    low_cnt = CW'(lo);
    high_cnt = CW'(hi);
    en = 1'b1;
    @(negedge clk);
    check(scl_pull == 1'b1, "R2 pull after enable", int'(scl_pull), 1);
  endtask

  task automatic free_period(input int lo, input int hi);
    int n = 0;
    int m = 0;
    int rs_at = -1;
    int rs_n = 0;
    int fs_n = 0;
    start_run(lo, hi);
    while (scl_pull && n < 100) begin
      if (fall_stb) fs_n++;
      n++;
      @(negedge clk);
    end
    check(n == exp_len(lo), "R3 low length", n, exp_len(lo));
    check(fs_n == 0, "R7 no fall from idle", fs_n, 0);
    while (!scl_pull && m < 100) begin
      if (rise_stb) begin rs_at = m; rs_n++; end
      m++;
      @(negedge clk);
    end
    check(m == exp_len(hi) + 1, "R5 released length", m, exp_len(hi) + 1);
    check(rs_at == 1 && rs_n == 1, "R7 rise position", rs_at, 1);
    check(fall_stb == 1'b1, "R7 fall at new low", int'(fall_stb), 1);
    @(negedge clk);
    check(fall_stb == 1'b0, "R7 fall one cycle", int'(fall_stb), 0);
  endtask

  task automatic stretch(input int lo, input int hi, input int s);
    int n = 0;
    int w = 0;
    start_run(lo, hi);
    slave_low = 1'b1;
    while (scl_pull && n < 100) begin n++; @(negedge clk); end
    check(n == exp_len(lo), "R3 low length under hold", n, exp_len(lo));
    for (int i = 0; i < s; i++) begin
      if (scl_wait && !scl_pull && !rise_stb) w++;
      @(negedge clk);
    end
    check(w == s, "R4 wait while held", w, s);
    slave_low = 1'b0;
    #1;
    check(scl_wait == 1'b0, "R4 wait drops on release", int'(scl_wait), 0);
    @(negedge clk);
    check(rise_stb == 1'b1 && scl_pull == 1'b0, "R5 high starts after release", int'(rise_stb), 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #3;
    check(!scl_pull && !scl_wait && !rise_stb && !fall_stb, "R1 reset outputs",
          int'({scl_pull, scl_wait, rise_stb, fall_stb}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!scl_pull && !scl_wait && !rise_stb && !fall_stb, "R1 disabled outputs",
          int'({scl_pull, scl_wait, rise_stb, fall_stb}), 0);

    // directed corners: clamp of 0/1, plain values
    free_period(0, 1);
    free_period(1, 0);
    free_period(2, 2);
    free_period(5, 3);

    // random periods
    for (int i = 0; i < 20; i++) begin
      free_period(int'($urandom_range(0, 14)), int'($urandom_range(0, 14)));
    end

    // slave stretching
    stretch(3, 4, 1);
    for (int i = 0; i < 8; i++) begin
      stretch(int'($urandom_range(0, 10)), int'($urandom_range(0, 10)),
              int'($urandom_range(1, 12)));
    end

    // competing master cuts the high phase short (R6)
    begin
      int n = 0;
      int g = 0;
      start_run(4, 10);
      while (scl_pull && g < 100) begin g++; @(negedge clk); end
      g = 0;
      while (!rise_stb && g < 100) begin g++; @(negedge clk); end
      @(negedge clk);
      other_low = 1'b1;
      @(negedge clk);
      check(scl_pull == 1'b1, "R6 low restarts on foreign fall", int'(scl_pull), 1);
      check(fall_stb == 1'b1, "R7 fall on aborted high", int'(fall_stb), 1);
      other_low = 1'b0;
      while (scl_pull && n < 100) begin n++; @(negedge clk); end
      check(n == 4, "R6 full low count reloaded", n, 4);
    end

    // disable in the middle of a low phase, then in a held wait
    begin
      int bad = 0;
      int g = 0;
      start_run(6, 6);
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      check(scl_pull == 1'b0, "R8 release after disable", int'(scl_pull), 0);
      for (int i = 0; i < 10; i++) begin
        if (scl_pull || scl_wait || rise_stb || fall_stb) bad++;
        @(negedge clk);
      end
      check(bad == 0, "R1 idle while disabled", bad, 0);
      start_run(2, 2);
      slave_low = 1'b1;
      while (scl_pull && g < 100) begin g++; @(negedge clk); end
      check(scl_wait == 1'b1, "R4 wait before disable", int'(scl_wait), 1);
      en = 1'b0;
      @(negedge clk);
      check(scl_wait == 1'b0 && scl_pull == 1'b0, "R8 wait cleared by disable",
            int'({scl_wait, scl_pull}), 0);
      slave_low = 1'b0;
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule